// File: doc/BRIEF.md
# System Segment Register Loader

This block carries out the two privileged instructions that point the processor at a local descriptor table or at a task state segment. A command gives a 16-bit selector and says which of the two registers is the target. The block takes the current privilege level, the protected-mode flag and the global descriptor table base and limit at the moment the command is accepted. It checks the selector first. It then reads the two 32-bit words of the descriptor from the global table, one at a time, over a request/response memory port, and checks the descriptor type and presence.

If every check passes, the cached selector, base, byte-granular limit, type and valid bit of the chosen register are updated. A task load also marks the descriptor busy in memory: the high word is read back and written with its busy bit set. Each command ends in one result pulse. The pulse carries either success or the first fault found, together with a fault class and a 16-bit error code.

Commands use a valid/ready handshake, and the block accepts a new command only while it is idle. The memory request channel is valid/ready as well. A request that is not accepted is held unchanged until memory takes it. The response channel has no back-pressure, because the block waits for each response and always takes it.

Top module: `sysreg_loader`

## Requirements
- R1: After reset, cmd_ready is 1, res_valid and mem_req_valid are 0, and both cached registers are invalid with selector, base, limit and type equal to zero.
- R2: With the protected-mode flag clear, a command ends with class 1 (invalid opcode) and code 0, makes no memory request, and reports its result in the second cycle after acceptance.
- R3: With privilege level not 0 (and the protected-mode flag set), a command ends with class 2 (protection) and code 0, and makes no memory request. This check outranks every selector check.
- R4: A local-table load whose selector has bits 15:2 all zero makes no memory request. It stores the selector, clears the local-table valid bit, leaves base and limit unchanged, and ends with class 0.
- R5: A task load whose selector has bits 15:2 all zero ends with class 2 and code 0.
- R6: A selector with bit 2 (table indicator) set ends with class 2 and a code equal to the selector with bits 1:0 cleared, and makes no memory request.
- R7: If index*8+7 is greater than the table limit (index = selector bits 15:3), the command ends with class 2 and the selector code, and makes no memory request.
- R8: The low descriptor word is read at base+index*8 and then the high word at base+index*8+4.
- R9: The type check uses high-word bit 12, which must be 0 (system descriptor), and high-word bits 11:8. The local table needs type 2. The task load needs type 1 or type 9. A mismatch ends with class 2 and the selector code.
- R10: A descriptor that passes the type check but has high-word bit 15 (present) clear ends with class 3 (not present) and the selector code. A type mismatch takes precedence over absence.
- R11: A successful load sets the valid bit and caches the selector. It caches the base {hi[31:24], hi[7:0], lo[31:16]}. It caches the limit {hi[19:16], lo[15:0]}, scaled to {limit20, 12'hFFF} when hi[23] is set. It caches the type hi[11:8]. It ends with class 0.
- R12: A successful task load caches the type with bit 1 set. If high-word bit 9 was clear, it writes the high word with bit 9 set to base+index*8+4 before reporting.
- R13: A command that ends with a fault leaves both cached registers unchanged.
- R14: An unaccepted memory request keeps its valid, address, write flag and data stable until mem_req_ready; while cmd_ready is 1 no memory request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command taken on valid and ready |
| cmd_target | input | 1 | 0 = local table register, 1 = task register |
| cmd_sel | input | 16 | Selector operand |
| prot_en | input | 1 | Protected-mode flag, sampled on acceptance |
| cur_pl | input | 2 | Current privilege level, sampled on acceptance |
| gdt_base | input | ADDR_W | Global table base, sampled on acceptance |
| gdt_limit | input | LIM_W | Global table limit in bytes, sampled on acceptance |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_class | output | 2 | 0 none, 1 invalid opcode, 2 protection, 3 not present |
| res_code | output | 16 | Error code |
| ldt_sel | output | 16 | Cached local-table selector |
| ldt_base | output | 32 | Cached local-table base |
| ldt_limit | output | 32 | Cached local-table byte limit |
| ldt_type | output | 4 | Cached local-table type |
| ldt_valid | output | 1 | Local-table cache valid |
| tr_sel | output | 16 | Cached task selector |
| tr_base | output | 32 | Cached task base |
| tr_limit | output | 32 | Cached task byte limit |
| tr_type | output | 4 | Cached task type, busy bit set |
| tr_valid | output | 1 | Task cache valid |

## Verification
A command is accepted on a rising edge. A command that fails a mode, privilege, null, table-indicator or limit check pulses res_valid in the second cycle after that edge. With memory that is always ready and answers one cycle after each read, a command that reaches the descriptor check reports in the seventh cycle. A successful task load reports in the eighth cycle because of its busy write. The bench counts falling edges from the accepting edge up to the first falling edge that shows res_valid. It checks that count against these figures in the sweeps that run without stalls. In the sweep with memory stalls it checks only the outcome, the request counts and the cached state.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int NUM_SLOTS    = 2;
  localparam int DESC_SHIFT   = 3;
  localparam int HI_WORD_OFS  = 4;
  localparam int BUSY_BIT     = 9;

  typedef enum logic [0:0] {
    TGT_LDT  = 1'b0,
    TGT_TASK = 1'b1
  } target_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_OPCODE = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_ABSENT = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_LO,
    ST_WT_LO,
    ST_RD_HI,
    ST_WT_HI,
    ST_EVAL,
    ST_WR_HI
  } state_e;

  localparam logic [3:0] DT_LOCAL_TABLE = 4'h2;
  localparam logic [3:0] DT_TSS16_FREE  = 4'h1;
  localparam logic [3:0] DT_TSS32_FREE  = 4'h9;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    logic [3:0]  dtype;
  } seg_cache_t;
endpackage

// File: rtl/sysreg_precheck.sv
module sysreg_precheck
  import sysreg_pkg::*;
#(
  parameter int LIM_W = 16
) (
  input  logic             pe,
  input  logic [1:0]       cpl,
  input  logic             tgt_task,
  input  logic [15:0]      sel,
  input  logic [LIM_W-1:0] gdt_limit,
  output fault_e           fault,
  output logic [15:0]      code,
  output logic             ldt_null
);
  localparam int CMP_W = (LIM_W > 16) ? LIM_W : 16;

  logic [CMP_W-1:0] span_end;
  logic [CMP_W-1:0] lim_ext;
  logic [15:0]      sel_code;
  logic             is_null;
  logic             unused_rpl;

  assign span_end   = CMP_W'({sel[15:DESC_SHIFT], {DESC_SHIFT{1'b1}}});
  assign lim_ext    = CMP_W'(gdt_limit);
  assign sel_code   = {sel[15:2], 2'b00};
  assign is_null    = (sel[15:2] == 14'd0);
  assign unused_rpl = ^sel[1:0];

  always_comb begin
    fault    = FLT_NONE;
    code     = 16'h0000;
    ldt_null = 1'b0;
    if (!pe) begin
      fault = FLT_OPCODE;
    end else if (cpl != 2'd0) begin
      fault = FLT_PROT;
    end else if (is_null) begin
      if (tgt_task) fault = FLT_PROT;
      else          ldt_null = 1'b1;
    end else if (sel[2]) begin
      fault = FLT_PROT;
      code  = sel_code;
    end else if (span_end > lim_ext) begin
      fault = FLT_PROT;
      code  = sel_code;
    end
  end
endmodule

// File: rtl/sysreg_desc_decode.sv
module sysreg_desc_decode
  import sysreg_pkg::*;
(
  input  logic        tgt_task,
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  output fault_e      fault,
  output logic        need_mark,
  output logic [31:0] mark_word,
  output seg_cache_t  cache
);
  logic        is_system;
  logic        present;
  logic        gran;
  logic [3:0]  dtype;
  logic [19:0] lim20;
  logic        type_ok;
  logic        unused_dec;

  assign is_system  = ~hi[12];
  assign present    = hi[15];
  assign gran       = hi[23];
  assign dtype      = hi[11:8];
  assign lim20      = {hi[19:16], lo[15:0]};
  assign unused_dec = ^{hi[22:20], hi[14:13]};

  always_comb begin
    if (!is_system)    type_ok = 1'b0;
    else if (tgt_task) type_ok = (dtype == DT_TSS16_FREE) || (dtype == DT_TSS32_FREE);
    else               type_ok = (dtype == DT_LOCAL_TABLE);
  end

  always_comb begin
    if (!type_ok)      fault = FLT_PROT;
    else if (!present) fault = FLT_ABSENT;
    else               fault = FLT_NONE;
  end

  assign need_mark   = tgt_task && !hi[BUSY_BIT];
  assign mark_word   = hi | (32'd1 << BUSY_BIT);
  assign cache.base  = {hi[31:24], hi[7:0], lo[31:16]};
  assign cache.limit = gran ? {lim20, 12'hFFF} : {12'h000, lim20};
  assign cache.dtype = tgt_task ? (dtype | 4'b0010) : dtype;
endmodule

// File: rtl/sysreg_slot.sv
module sysreg_slot
  import sysreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        clear,
  input  logic [15:0] sel_in,
  input  seg_cache_t  cache_in,
  output logic [15:0] sel_q,
  output seg_cache_t  cache_q,
  output logic        valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 16'h0000;
      cache_q <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      sel_q   <= sel_in;
      cache_q <= cache_in;
      valid_q <= 1'b1;
    end else if (clear) begin
      sel_q   <= sel_in;
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sysreg_loader.sv
module sysreg_loader
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_target,
  input  logic [15:0]       cmd_sel,
  input  logic              prot_en,
  input  logic [1:0]        cur_pl,
  input  logic [ADDR_W-1:0] gdt_base,
  input  logic [LIM_W-1:0]  gdt_limit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [15:0]       res_code,
  output logic [15:0]       ldt_sel,
  output logic [31:0]       ldt_base,
  output logic [31:0]       ldt_limit,
  output logic [3:0]        ldt_type,
  output logic              ldt_valid,
  output logic [15:0]       tr_sel,
  output logic [31:0]       tr_base,
  output logic [31:0]       tr_limit,
  output logic [3:0]        tr_type,
  output logic              tr_valid
);
  state_e            st;
  logic              tgt_q;
  logic [15:0]       sel_q;
  logic              pe_q;
  logic [1:0]        cpl_q;
  logic [ADDR_W-1:0] base_q;
  logic [LIM_W-1:0]  lim_q;
  logic [31:0]       lo_q;
  logic [31:0]       hi_q;
  fault_e            res_class_q;

  fault_e            pre_fault;
  logic [15:0]       pre_code;
  logic              pre_ldt_null;
  fault_e            dec_fault;
  logic              dec_need_mark;
  logic [31:0]       dec_mark_word;
  seg_cache_t        dec_cache;
  logic [ADDR_W-1:0] desc_addr;
  logic [ADDR_W-1:0] hi_addr;
  logic [15:0]       sel_code;

  sysreg_precheck #(.LIM_W(LIM_W)) u_precheck (
    .pe        (pe_q),
    .cpl       (cpl_q),
    .tgt_task  (tgt_q),
    .sel       (sel_q),
    .gdt_limit (lim_q),
    .fault     (pre_fault),
    .code      (pre_code),
    .ldt_null  (pre_ldt_null)
  );

  sysreg_desc_decode u_decode (
    .tgt_task  (tgt_q),
    .lo        (lo_q),
    .hi        (hi_q),
    .fault     (dec_fault),
    .need_mark (dec_need_mark),
    .mark_word (dec_mark_word),
    .cache     (dec_cache)
  );

  assign desc_addr = base_q + ADDR_W'({sel_q[15:DESC_SHIFT], {DESC_SHIFT{1'b0}}});
  assign hi_addr   = desc_addr + ADDR_W'(HI_WORD_OFS);
  assign sel_code  = {sel_q[15:2], 2'b00};

  assign cmd_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_RD_LO) || (st == ST_RD_HI) || (st == ST_WR_HI);
  assign mem_req_we    = (st == ST_WR_HI);
  assign mem_req_addr  = (st == ST_RD_LO) ? desc_addr : hi_addr;
  assign mem_req_wdata = (st == ST_WR_HI) ? dec_mark_word : 32'h0000_0000;
  assign res_class     = res_class_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      tgt_q       <= 1'b0;
      sel_q       <= 16'h0000;
      pe_q        <= 1'b0;
      cpl_q       <= 2'd0;
      base_q      <= '0;
      lim_q       <= '0;
      lo_q        <= 32'h0;
      hi_q        <= 32'h0;
      res_valid   <= 1'b0;
      res_class_q <= FLT_NONE;
      res_code    <= 16'h0000;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            tgt_q  <= cmd_target;
            sel_q  <= cmd_sel;
            pe_q   <= prot_en;
            cpl_q  <= cur_pl;
            base_q <= gdt_base;
            lim_q  <= gdt_limit;
            st     <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if ((pre_fault != FLT_NONE) || pre_ldt_null) begin
            res_valid   <= 1'b1;
            res_class_q <= pre_fault;
            res_code    <= pre_code;
            st          <= ST_IDLE;
          end else begin
            st <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_req_ready) st <= ST_WT_LO;
        ST_WT_LO: begin
          if (mem_rsp_valid) begin
            lo_q <= mem_rsp_data;
            st   <= ST_RD_HI;
          end
        end
        ST_RD_HI: if (mem_req_ready) st <= ST_WT_HI;
        ST_WT_HI: begin
          if (mem_rsp_valid) begin
            hi_q <= mem_rsp_data;
            st   <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (dec_fault != FLT_NONE) begin
            res_valid   <= 1'b1;
            res_class_q <= dec_fault;
            res_code    <= sel_code;
            st          <= ST_IDLE;
          end else if (dec_need_mark) begin
            st <= ST_WR_HI;
          end else begin
            res_valid   <= 1'b1;
            res_class_q <= FLT_NONE;
            res_code    <= 16'h0000;
            st          <= ST_IDLE;
          end
        end
        ST_WR_HI: begin
          if (mem_req_ready) begin
            res_valid   <= 1'b1;
            res_class_q <= FLT_NONE;
            res_code    <= 16'h0000;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [15:0] slot_sel   [NUM_SLOTS];
  seg_cache_t  slot_cache [NUM_SLOTS];
  logic        slot_valid [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic slot_load;
    logic slot_clear;
    assign slot_load  = (st == ST_EVAL) && (dec_fault == FLT_NONE) && (int'(tgt_q) == g);
    assign slot_clear = (st == ST_CHECK) && (pre_fault == FLT_NONE) && pre_ldt_null &&
                        (int'(tgt_q) == g);
    sysreg_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (slot_load),
      .clear    (slot_clear),
      .sel_in   (sel_q),
      .cache_in (dec_cache),
      .sel_q    (slot_sel[g]),
      .cache_q  (slot_cache[g]),
      .valid_q  (slot_valid[g])
    );
  end

  assign ldt_sel   = slot_sel[int'(TGT_LDT)];
  assign ldt_base  = slot_cache[int'(TGT_LDT)].base;
  assign ldt_limit = slot_cache[int'(TGT_LDT)].limit;
  assign ldt_type  = slot_cache[int'(TGT_LDT)].dtype;
  assign ldt_valid = slot_valid[int'(TGT_LDT)];
  assign tr_sel    = slot_sel[int'(TGT_TASK)];
  assign tr_base   = slot_cache[int'(TGT_TASK)].base;
  assign tr_limit  = slot_cache[int'(TGT_TASK)].limit;
  assign tr_type   = slot_cache[int'(TGT_TASK)].dtype;
  assign tr_valid  = slot_valid[int'(TGT_TASK)];
endmodule

// File: rtl/sysreg_loader_chk.sv
module sysreg_loader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              res_valid,
  input logic [1:0]        res_class,
  input logic [15:0]       res_code,
  input logic [15:0]       ldt_sel,
  input logic              ldt_valid,
  input logic [15:0]       tr_sel,
  input logic [3:0]        tr_type,
  input logic              tr_valid
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
    $stable(mem_req_we) && $stable(mem_req_wdata)); // R14

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_req_valid); // R14

  AST_OPCODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_class == 2'd1) |-> (res_code == 16'h0000)); // R2

  AST_ABSENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_class == 2'd3) |-> (res_code[1:0] == 2'b00) && (res_code != 16'h0)); // R10

  AST_MARK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[9]); // R12

  AST_TASK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |-> tr_type[1]); // R12

  AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_class != 2'd0) |-> $stable(ldt_valid) && $stable(tr_valid) &&
    $stable(ldt_sel) && $stable(tr_sel)); // R13
endmodule

bind sysreg_loader sysreg_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .res_valid     (res_valid),
  .res_class     (res_class),
  .res_code      (res_code),
  .ldt_sel       (ldt_sel),
  .ldt_valid     (ldt_valid),
  .tr_sel        (tr_sel),
  .tr_type       (tr_type),
  .tr_valid      (tr_valid)
);

// File: tb/sysreg_loader_bench.sv
module sysreg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] GBASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_target = 1'b0;
  logic [15:0] cmd_sel = 16'h0;
  logic        prot_en = 1'b1;
  logic [1:0]  cur_pl = 2'd0;
  logic [31:0] gdt_base = GBASE;
  logic [15:0] gdt_limit = 16'h004F;
  logic        mem_req_valid, mem_req_we, mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;
  logic        res_valid;
  logic [1:0]  res_class;
  logic [15:0] res_code, ldt_sel, tr_sel;
  logic [31:0] ldt_base, ldt_limit, tr_base, tr_limit;
  logic [3:0]  ldt_type, tr_type;
  logic        ldt_valid, tr_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysreg_loader u_sysreg_loader (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_target(cmd_target), .cmd_sel(cmd_sel), .prot_en(prot_en), .cur_pl(cur_pl),
    .gdt_base(gdt_base), .gdt_limit(gdt_limit), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_class(res_class), .res_code(res_code),
    .ldt_sel(ldt_sel), .ldt_base(ldt_base), .ldt_limit(ldt_limit), .ldt_type(ldt_type),
    .ldt_valid(ldt_valid), .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit),
    .tr_type(tr_type), .tr_valid(tr_valid)
  );

  // bench memory: 16 descriptors of two words each
  logic [31:0] gmem [32];
  logic        poke_en = 1'b0;
  logic [4:0]  poke_idx = 5'd0;
  logic [31:0] poke_data = 32'h0;
  logic        stall_en = 1'b0;
  logic [1:0]  stall_cnt = 2'd0;
  int          nreq = 0, nwr = 0, nrd = 0;
  logic [31:0] rd_log [2];
  logic [31:0] wr_addr = 32'h0;

  assign mem_req_ready = !stall_en || stall_cnt[1];

  function automatic logic [4:0] word_idx(input logic [31:0] a);
    logic [31:0] off;
    off = (a - GBASE) >> 2;
    return off[4:0];
  endfunction

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    mem_rsp_valid <= 1'b0;
    if (poke_en) gmem[poke_idx] <= poke_data;
    if (mem_req_valid && mem_req_ready) begin
      nreq <= nreq + 1;
      if (mem_req_we) begin
        nwr <= nwr + 1;
        wr_addr <= mem_req_addr;
        gmem[word_idx(mem_req_addr)] <= mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= gmem[word_idx(mem_req_addr)];
        rd_log[nrd % 2] <= mem_req_addr;
        nrd <= nrd + 1;
      end
    end
  end

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // shadow of the cached registers
  logic [15:0] s_ldt_sel = 0, s_tr_sel = 0;
  logic [31:0] s_ldt_base = 0, s_ldt_lim = 0, s_tr_base = 0, s_tr_lim = 0;
  logic [3:0]  s_ldt_type = 0, s_tr_type = 0;
  logic        s_ldt_val = 0, s_tr_val = 0;

  logic [1:0]  r_class;
  logic [15:0] r_code;
  int          r_lat, r_reqs, r_wrs;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(req, "ldt sel/valid", {15'd0, ldt_valid, ldt_sel}, {15'd0, s_ldt_val, s_ldt_sel});
    check(req, "ldt base", ldt_base, s_ldt_base);
    check(req, "ldt limit", ldt_limit, s_ldt_lim);
    check(req, "ldt type", {28'd0, ldt_type}, {28'd0, s_ldt_type});
    check(req, "tr sel/valid", {15'd0, tr_valid, tr_sel}, {15'd0, s_tr_val, s_tr_sel});
    check(req, "tr base", tr_base, s_tr_base);
    check(req, "tr limit", tr_limit, s_tr_lim);
    check(req, "tr type", {28'd0, tr_type}, {28'd0, s_tr_type});
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_idx = idx[4:0]; poke_data = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [63:0] make_desc(input logic [31:0] b, input logic [19:0] l,
      input logic g, input logic p, input logic s, input logic [3:0] t);
    logic [31:0] lo, hi;
    lo = {b[15:0], l[15:0]};
    hi = {b[31:24], g, 3'b000, l[19:16], p, 2'b00, s, t, b[23:16]};
    return {hi, lo};
  endfunction

  function automatic logic [31:0] exp_lim(input logic [19:0] l, input logic g);
    return g ? {l, 12'hFFF} : {12'h000, l};
  endfunction

  task automatic put_desc(input int slot, input logic [63:0] d);
    poke(slot * 2, d[31:0]);
    poke(slot * 2 + 1, d[63:32]);
  endtask

  task automatic run(input logic tgt, input logic [15:0] sel);
    int r0, w0, n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_target = tgt; cmd_sel = sel;
    r0 = nreq; w0 = nwr;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!res_valid && n < 400);
    r_class = res_class; r_code = res_code; r_lat = n;
    r_reqs = nreq - r0; r_wrs = nwr - w0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) gmem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "cmd_ready", {31'd0, cmd_ready}, 32'd1);
    check("R1", "res/req valid", {30'd0, res_valid, mem_req_valid}, 32'd0);
    check_regs("R1");

    // local-table descriptors at indices 1..15
    for (int i = 1; i < 16; i++)
      put_desc(i, make_desc(32'h0040_0000 + i * 32'h1000, 20'h000FF + i, 1'b0, 1'b1, 1'b0, 4'h2));

    // R2/R3: mode and privilege sweep, both targets, selector with TI set
    for (int t = 0; t < 2; t++)
      for (int pe = 0; pe < 2; pe++)
        for (int c = 0; c < 4; c++) begin
          if (pe == 1 && c == 0) continue;
          prot_en = pe[0]; cur_pl = c[1:0];
          run(t[0], 16'h000F);
          if (pe == 0) begin
            check("R2", "class", {30'd0, r_class}, 32'd1);
            check("R2", "code", {16'd0, r_code}, 32'd0);
            check("R2", "latency", r_lat, 32'd2);
            check("R2", "requests", r_reqs, 32'd0);
          end else begin
            check("R3", "class", {30'd0, r_class}, 32'd2);
            check("R3", "code", {16'd0, r_code}, 32'd0);
            check("R3", "requests", r_reqs, 32'd0);
          end
          check_regs("R13");
        end
    prot_en = 1'b1; cur_pl = 2'd0;

    // set up a valid local table, then null selectors
    run(1'b0, 16'h0008);
    check("R11", "class", {30'd0, r_class}, 32'd0);
    s_ldt_sel = 16'h0008; s_ldt_base = 32'h0040_1000; s_ldt_lim = 32'h0000_0100;
    s_ldt_type = 4'h2; s_ldt_val = 1'b1;
    check_regs("R11");
    for (int sv = 0; sv < 4; sv++) begin
      run(1'b0, sv[15:0]);
      check("R4", "class", {30'd0, r_class}, 32'd0);
      check("R4", "requests", r_reqs, 32'd0);
      check("R4", "latency", r_lat, 32'd2);
      s_ldt_sel = sv[15:0]; s_ldt_val = 1'b0;
      check_regs("R4");
      run(1'b1, sv[15:0]);
      check("R5", "class", {30'd0, r_class}, 32'd2);
      check("R5", "code", {16'd0, r_code}, 32'd0);
      check_regs("R13");
    end

    // R6/R7/R14: table indicator and limit sweep with memory stalls
    stall_en = 1'b1;
    for (int idx = 1; idx < 16; idx++)
      for (int ti = 0; ti < 2; ti++)
        for (int rpl = 0; rpl < 4; rpl++) begin
          logic [15:0] sel;
          int ec;
          sel = {idx[12:0], ti[0], rpl[1:0]};
          run(1'b0, sel);
          if (ti == 1) ec = 2;
          else if (idx * 8 + 7 > 32'h4F) ec = 2;
          else ec = 0;
          if (ec != 0) begin
            check(ti == 1 ? "R6" : "R7", "class", {30'd0, r_class}, 32'd2);
            check(ti == 1 ? "R6" : "R7", "code", {16'd0, r_code}, {16'd0, sel & 16'hFFFC});
            check(ti == 1 ? "R6" : "R7", "requests", r_reqs, 32'd0);
            check_regs("R13");
          end else begin
            check("R14", "class", {30'd0, r_class}, 32'd0);
            check("R14", "requests", r_reqs, 32'd2);
            s_ldt_sel = sel; s_ldt_base = 32'h0040_0000 + idx * 32'h1000;
            s_ldt_lim = 32'h0000_00FF + idx; s_ldt_type = 4'h2; s_ldt_val = 1'b1;
            check_regs("R11");
          end
        end
    stall_en = 1'b0;

    // R7: limit boundary, last byte of index 9 just outside
    gdt_limit = 16'h004E;
    run(1'b0, 16'h0048);
    check("R7", "boundary class", {30'd0, r_class}, 32'd2);
    check("R7", "boundary code", {16'd0, r_code}, 32'h48);
    gdt_limit = 16'h004F;
    run(1'b0, 16'h0048);
    check("R7", "inside class", {30'd0, r_class}, 32'd0);
    s_ldt_sel = 16'h0048; s_ldt_base = 32'h0040_9000; s_ldt_lim = 32'h108;
    s_ldt_type = 4'h2; s_ldt_val = 1'b1;
    check_regs("R7");

    // R8..R12: type, system flag and present sweep on index 3
    for (int t = 0; t < 2; t++)
      for (int ty = 0; ty < 16; ty++)
        for (int s = 0; s < 2; s++)
          for (int p = 0; p < 2; p++) begin
            logic [31:0] b;
            logic [19:0] l;
            logic        g;
            logic [63:0] d;
            logic        ok;
            int          ecl;
            b = 32'hA15C_3E00 + ty * 32'h0101_0101 + s * 32'h10 + p;
            l = 20'h12345 ^ {16'd0, ty[3:0]};
            g = ty[0] ^ p[0];
            d = make_desc(b, l, g, p[0], s[0], ty[3:0]);
            put_desc(3, d);
            if (s == 1) ok = 1'b0;
            else if (t == 1) ok = (ty == 1) || (ty == 9);
            else ok = (ty == 2);
            ecl = !ok ? 2 : (p == 0 ? 3 : 0);
            run(t[0], 16'h0018);
            check(ecl == 3 ? "R10" : (ecl == 2 ? "R9" : (t == 1 ? "R12" : "R11")),
                  "class", {30'd0, r_class}, ecl);
            check("R9", "code", {16'd0, r_code}, ecl == 0 ? 32'd0 : 32'h18);
            check("R8", "low addr", rd_log[0], GBASE + 32'h18);
            check("R8", "high addr", rd_log[1], GBASE + 32'h1C);
            if (ecl == 0 && t == 1) begin
              check("R12", "latency", r_lat, 32'd8);
              check("R12", "writes", r_wrs, 32'd1);
              check("R12", "write addr", wr_addr, GBASE + 32'h1C);
              check("R12", "marked word", gmem[7], d[63:32] | 32'h200);
              s_tr_sel = 16'h0018; s_tr_base = b; s_tr_lim = exp_lim(l, g);
              s_tr_type = ty[3:0] | 4'h2; s_tr_val = 1'b1;
              check_regs("R12");
            end else begin
              check("R8", "latency", r_lat, 32'd7);
              check("R8", "writes", r_wrs, 32'd0);
              if (ecl == 0) begin
                s_ldt_sel = 16'h0018; s_ldt_base = b; s_ldt_lim = exp_lim(l, g);
                s_ldt_type = ty[3:0]; s_ldt_val = 1'b1;
                check_regs("R11");
              end else begin
                check_regs("R13");
              end
            end
          end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule